// File: doc/BRIEF.md
# Autobaud Low-Period Meter

This block measures how long an incoming serial line stays low, so that software can work out the bit rate of a remote transmitter. Software arms the meter by setting a start bit in the control register. The meter then waits for the line to fall and counts reference clock cycles. When the line rises again the meter latches the count, raises an interrupt and, while still armed, stops by itself and clears the start bit.

If software clears the start bit while a count is in progress, the count is not abandoned. The meter keeps running and raises the interrupt again on every later rising edge. Setting the start bit again in that state brings back the normal stop on the next rising edge. Reading the busy flag together with the start bit gives four states: idle, launched (armed and waiting for the fall), counting (armed and waiting for the rise) and abnormal (counting with the start bit clear).

The serial input passes through a synchronizer before edge detection. A rise or fall on `rx_i` therefore reaches the counter a fixed few cycles late. The same delay applies to both edges, so the measured interval is not changed.

Top module: `abaud_meter`

## Requirements
- R1: After reset, reading address 0 (control), 1 (status) or 2 (count) returns 0, and `irq_o` is low.
- R2: Writing 1 to control bit 0 (start) arms the meter, and control bit 0 reads back 1. Status bit 0 (busy) stays 0 until a falling edge of `rx_i`, and becomes 1 within four cycles after it.
- R3: With the meter armed, the value latched into the count register at the rising edge equals the number of reference clock cycles that `rx_i` was held low.
- R4: A rising edge while busy with start set clears busy and clears control bit 0. It also sets status bit 1 (interrupt pending) and drives `irq_o` high.
- R5: Writing status with bit 1 set clears the pending interrupt. Writing status with bit 1 clear leaves it set. `irq_o` always equals status bit 1.
- R6: If a rising edge that raises the interrupt falls in the same cycle as a status write that clears it, the interrupt stays pending.
- R7: Clearing start while busy does not stop the count. Every later rising edge raises the interrupt and latches the number of cycles since the falling edge that began the count, while busy stays 1.
- R8: Setting start again while in the abnormal state makes the next rising edge end the count as in R4.
- R9: Clearing start before any falling edge returns the meter to idle. Later pulses on `rx_i` then start no count, raise no interrupt and leave the count register unchanged.
- R10: The count saturates at 2^CNT_W-1 when the line stays low longer than that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one count per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status |
| wr_data | input | 2 | Write data: bit 0 start (control), bit 1 clear-pending (status) |
| rd_addr | input | 2 | Read address: 0 control, 1 status, 2 count |
| rd_data | output | CNT_W | Read data for rd_addr, zero-extended |
| irq_o | output | 1 | Interrupt, high while pending |

## Verification
The two functions that can meet in one cycle are the hardware setting the interrupt on a detected rising edge and software clearing it through a status write. The bench counts the synchronizer stages from the rise of `rx_i`, so that the clearing write is sampled at exactly the edge where the rise is acted on. It then expects the interrupt still pending, and expects a second write one cycle later to clear it. A similar timing collision in the abnormal state is judged by tracking cycle numbers. The expected count is the distance in cycles between the line edges the bench drove.

// File: rtl/abaud_pkg.sv
// Shared register map and field positions for the autobaud meter.
// Assumes a two-bit register address space; count width is set per instance.
package abaud_pkg;
    localparam int ADDR_W = 2;
    localparam int WDAT_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd2;

    localparam int BIT_START = 0;  // control: arm
    localparam int BIT_BUSY  = 0;  // status: counting in progress
    localparam int BIT_PEND  = 1;  // status: interrupt pending, write one to clear

    // Decoded meter phase, derived from busy and start.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_LAUNCHED = 2'd1,
        PH_ABNORMAL = 2'd2,
        PH_COUNTING = 2'd3
    } abaud_phase_t;

    function automatic abaud_phase_t decode_phase(input logic busy, input logic start);
        return abaud_phase_t'({busy, start});
    endfunction
endpackage

// File: rtl/abaud_rx_sync.sv
// Synchronizes the asynchronous serial line and produces single-cycle
// rise and fall pulses. Assumes the line idles high, so every stage
// resets to one and no edge is reported out of reset.
module abaud_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    // Shift the raw line through the synchronizer chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], rx_i};
            end
        end
    endgenerate

    assign level = sync_q[STAGES-1];

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    // Edge pulses from the current and previous level.
    always_comb begin
        rise_o = level & ~prev_q;
        fall_o = ~level & prev_q;
    end
endmodule

// File: rtl/abaud_engine.sv
// Counting engine: starts on a falling edge while armed, counts reference
// cycles with saturation, and flags rising edges seen while busy. A rise
// ends the count only when the start bit is still set; otherwise the
// engine keeps running. Assumes start_i comes from a register.
module abaud_engine #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             busy_o,
    output logic             hit_o,
    output logic             stop_o,
    output logic [CNT_W-1:0] run_o
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic             busy_q;
    logic [CNT_W-1:0] run_q;

    // Busy flag and saturating cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            run_q  <= '0;
        end else if (!busy_q) begin
            if (start_i && fall_i) begin
                busy_q <= 1'b1;
                run_q  <= {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end else begin
            if (rise_i && start_i) busy_q <= 1'b0;
            if (run_q != RUN_MAX)  run_q  <= run_q + 1'b1;
        end
    end

    // Event outputs toward the register bank.
    always_comb begin
        busy_o = busy_q;
        run_o  = run_q;
        hit_o  = busy_q & rise_i;
        stop_o = busy_q & rise_i & start_i;
    end
endmodule

// File: rtl/abaud_regs.sv
// Register bank: start bit, pending interrupt (write one to clear) and the
// latched count, with a combinational read port. A software write to the
// start bit wins over the hardware clear; a hardware interrupt set wins
// over a software clear in the same cycle.
module abaud_regs
    import abaud_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WDAT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy_i,
    input  logic              hit_i,
    input  logic              stop_i,
    input  logic [CNT_W-1:0]  run_i,
    output logic              start_o,
    output logic              pend_o,
    output logic [CNT_W-1:0]  rd_data
);
    logic             start_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ctrl;
    logic             clr_pend;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
        clr_pend = wr_en && (wr_addr == ADR_STAT) && wr_data[BIT_PEND];
    end

    // Start bit: software write first, then self-clear on normal stop.
    always_ff @(posedge clk) begin
        if (!rst_n)       start_q <= 1'b0;
        else if (wr_ctrl) start_q <= wr_data[BIT_START];
        else if (stop_i)  start_q <= 1'b0;
    end

    // Pending interrupt: set on every rise while busy, cleared by write one.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (hit_i)    pend_q <= 1'b1;
        else if (clr_pend) pend_q <= 1'b0;
    end

    // Latch the running count whenever the interrupt is raised.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (hit_i) cnt_q <= run_i;
    end

    // Read multiplexer, fields zero-extended.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL:  rd_data[BIT_START] = start_q;
            ADR_STAT: begin
                rd_data[BIT_BUSY] = busy_i;
                rd_data[BIT_PEND] = pend_q;
            end
            ADR_COUNT: rd_data = cnt_q;
            default:   rd_data = '0;
        endcase
    end

    assign start_o = start_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/abaud_meter.sv
// Top of the autobaud low-period meter: synchronizer, counting engine and
// register bank. Assumes CNT_W >= 2 so status fields fit the read port.
module abaud_meter
    import abaud_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WDAT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_o
);
    logic             rise_evt;
    logic             fall_evt;
    logic             start_q;
    logic             busy;
    logic             hit;
    logic             stop;
    logic [CNT_W-1:0] run_cnt;

    abaud_rx_sync #(.STAGES(SYNC_ST)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rise_o (rise_evt),
        .fall_o (fall_evt)
    );

    abaud_engine #(.CNT_W(CNT_W)) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_q),
        .rise_i  (rise_evt),
        .fall_i  (fall_evt),
        .busy_o  (busy),
        .hit_o   (hit),
        .stop_o  (stop),
        .run_o   (run_cnt)
    );

    abaud_regs #(.CNT_W(CNT_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .busy_i  (busy),
        .hit_i   (hit),
        .stop_i  (stop),
        .run_i   (run_cnt),
        .start_o (start_q),
        .pend_o  (irq_o),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/abaud_meter_chk.sv
// Property checker for the autobaud meter, bound to the top module.
// Observes edge pulses, start bit, busy flag, running count and interrupt.
module abaud_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise_evt,
    input logic             fall_evt,
    input logic             start_q,
    input logic             busy,
    input logic [CNT_W-1:0] run_cnt,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rise_evt) |=> irq_o);  // R4

    AST_STOP_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rise_evt && start_q) |=> !busy);  // R4

    AST_NO_ABORT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_q) |=> busy);  // R7

    AST_LAUNCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_q && fall_evt));  // R9

    AST_IRQ_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(busy && rise_evt));  // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt == RUN_MAX) |=> (run_cnt == RUN_MAX));  // R10
endmodule

bind abaud_meter abaud_meter_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .start_q  (start_q),
    .busy     (busy),
    .run_cnt  (run_cnt),
    .irq_o    (irq_o)
);

// File: tb/test_abaud_meter.sv
// Bench for the autobaud meter with a 6-bit counter: sweeps low periods,
// saturation, the abnormal state and the set/clear collision.
module test_abaud_meter;
    localparam int CW  = 6;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_i = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [1:0]    wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ncyc     = 0;
    bit finished = 0;

    abaud_meter #(.CNT_W(CW)) i_abaud_meter (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Armed measurement of a low pulse of len cycles.
    task automatic measure(input int len, input string req);
        int v;
        wr(2'd0, 2'b01);
        idle(2);
        rx_i = 1'b0;
        repeat (len) @(negedge clk);
        rx_i = 1'b1;
        idle(5);
        rd(2'd2, v); check(req, v, (len > MAXV) ? MAXV : len);
        rd(2'd1, v); check("R4 status", v, 2);
        rd(2'd0, v); check("R4 ctrl", v, 0);
        check("R4 irq", int'(irq_o), 1);
        wr(2'd1, 2'b10);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v, t_fall, t_rise;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 status", v, 0);
        rd(2'd2, v); check("R1 count", v, 0);
        check("R1 irq", int'(irq_o), 0);

        // R2 launched then counting
        wr(2'd0, 2'b01);
        idle(3);
        rd(2'd0, v); check("R2 ctrl armed", v, 1);
        rd(2'd1, v); check("R2 launched not busy", v, 0);
        rx_i = 1'b0;
        idle(4);
        rd(2'd1, v); check("R2 busy after fall", v, 1);
        idle(3);
        rx_i = 1'b1;
        idle(5);
        rd(2'd2, v); check("R3 first count", v, 7);
        // R5 write with bit1 clear keeps pending, bit1 set clears it
        wr(2'd1, 2'b01);
        rd(2'd1, v); check("R5 no clear", v, 2);
        wr(2'd1, 2'b10);
        rd(2'd1, v); check("R5 cleared", v, 0);
        check("R5 irq low", int'(irq_o), 0);

        // R3 sweep of low periods, R10 saturation
        for (int len = 1; len <= 40; len++) measure(len, "R3 sweep");
        measure(MAXV, "R10 at max");
        measure(70, "R10 saturate");

        // R6 collision: clearing write lands on the rise-detect edge
        wr(2'd0, 2'b01);
        idle(2);
        rx_i = 1'b0;
        idle(6);
        rx_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 2'b10;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd1, v); check("R6 set wins", v, 2);
        rd(2'd2, v); check("R6 count", v, 6);
        wr(2'd1, 2'b10);
        check("R6 later clear", int'(irq_o), 0);

        // R7 abnormal: clear start during count
        wr(2'd0, 2'b01);
        idle(2);
        rx_i = 1'b0; t_fall = ncyc;
        idle(5);
        wr(2'd0, 2'b00);
        idle(2);
        rx_i = 1'b1; t_rise = ncyc;
        idle(5);
        rd(2'd1, v); check("R7 busy and pending", v, 3);
        rd(2'd2, v); check("R7 first latch", v, t_rise - t_fall);
        wr(2'd1, 2'b10);
        rd(2'd1, v); check("R7 still busy", v, 1);
        rx_i = 1'b0;
        idle(3);
        rx_i = 1'b1; t_rise = ncyc;
        idle(5);
        rd(2'd1, v); check("R7 second irq", v, 3);
        rd(2'd2, v); check("R7 second latch", v, t_rise - t_fall);
        wr(2'd1, 2'b10);

        // R8 re-arm in abnormal, next rise stops
        wr(2'd0, 2'b01);
        rx_i = 1'b0;
        idle(2);
        rx_i = 1'b1; t_rise = ncyc;
        idle(5);
        rd(2'd1, v); check("R8 stopped", v, 2);
        rd(2'd0, v); check("R8 start cleared", v, 0);
        rd(2'd2, v); check("R8 latch", v, t_rise - t_fall);
        wr(2'd1, 2'b10);

        // R9 launched then disarmed: pulses ignored
        wr(2'd0, 2'b01);
        idle(2);
        wr(2'd0, 2'b00);
        for (int p = 0; p < 3; p++) begin
            rx_i = 1'b0; idle(4 + p);
            rx_i = 1'b1; idle(4);
        end
        rd(2'd1, v); check("R9 idle status", v, 0);
        rd(2'd2, v); check("R9 count kept", v, t_rise - t_fall);
        check("R9 irq low", int'(irq_o), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule